// File: doc/BRIEF.md
# Polled Four-Requester SRAM Arbiter

The block shares one single-port asynchronous SRAM among four requesters: a host link, a disk transfer engine, an image processing engine and a camera capture path. A small state machine visits the ports in a fixed rotation. At each stop it looks at the port's request line. If the line is low it moves on after one cycle. If it is high it latches the port's direction, address and write byte, runs one SRAM access, pulses that port's acknowledge and then moves to the next port. Each visit serves at most one access, so a busy port cannot starve the others.

Every requester has its own request, write-enable, address, write data, read data and acknowledge. A requester holds its request and operands steady until it sees its acknowledge. If it keeps the request high after the acknowledge, that counts as a new access and is served on the port's next visit. The SRAM side has active-low chip select, output enable and write strobe, a registered address and write-data bus, and a separate read-data input.

An access takes three cycles: the polling cycle that latches the operands, a setup cycle with the chip selected, and a strobe cycle. For a write, the strobe cycle pulses the write strobe. For a read, it captures the read byte. The acknowledge and the read byte appear together in the cycle that follows, which is also the next port's polling cycle.

Top module: `memArbiter`

## Requirements
- R1: While reset is held, the chip select, output enable and write strobe are all high (inactive), every acknowledge is low and busy is low.
- R2: After reset the rotation starts at port 0 and runs 0, 1, ..., NUM_PORTS-1, 0. With every port requesting from reset release, port p is acknowledged 3*(p+1) cycles after release, in port order.
- R3: A port with no request costs one cycle. A lone request held high after its acknowledge is served on the port's next visit, so its acknowledges come exactly NUM_PORTS+2 cycles apart.
- R4: A write stores the port's write byte at the port's address. A read returns the byte stored there on that port's read-data output, valid in the acknowledge cycle and held until that port's next read completes.
- R5: Acknowledge is a single-cycle pulse, and at most one port is acknowledged in any cycle.
- R6: During a write, the write strobe is low for exactly one cycle with the chip selected. The SRAM address and write data are identical in the cycle before the strobe, the strobe cycle and the cycle after it.
- R7: During a read, the output enable is low with the chip selected and the write strobe stays high. Output enable and write strobe are never low together.
- R8: Busy is high exactly while the SRAM is selected, which is two consecutive cycles per access.
- R9: Between a port raising its request and that port's acknowledge, at most NUM_PORTS-1 accesses for other ports complete, which bounds the wait to 3*NUM_PORTS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_PORTS | Per-port access request, held until acknowledged |
| weIn | input | NUM_PORTS | Per-port direction, 1 = write, 0 = read |
| addrIn | input | NUM_PORTS*ADDR_W | Per-port address, port p in bits [p*ADDR_W +: ADDR_W] |
| wdataIn | input | NUM_PORTS*DATA_W | Per-port write byte, port p in bits [p*DATA_W +: DATA_W] |
| rdataOut | output | NUM_PORTS*DATA_W | Per-port read byte, port p in bits [p*DATA_W +: DATA_W] |
| ackOut | output | NUM_PORTS | Per-port one-cycle completion pulse |
| busyOut | output | 1 | An SRAM access is in progress |
| sramAddr | output | ADDR_W | SRAM address |
| sramWdata | output | DATA_W | SRAM write data |
| sramRdata | input | DATA_W | SRAM read data |
| sramCeN | output | 1 | SRAM chip select, active low |
| sramOeN | output | 1 | SRAM output enable, active low |
| sramWeN | output | 1 | SRAM write strobe, active low |

## Verification
The bench builds the block with all four ports, 8-bit data and a 6-bit address, so that a full 64-byte SRAM model fits in the bench. With this model every written byte can be read back through a different port. Keeping four ports means the full rotation, the wrap from the last port to port 0 and the NUM_PORTS-1 bound on other ports' accesses all occur exactly as in the default build. A shorter address changes only the latched field width and leaves no control path unreached.

// File: rtl/arbPkg.sv
package arbPkg;

  // Per-visit phases of the polling state machine.
  typedef enum logic [1:0] {
    ST_CHECK  = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } arbState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic latch;    // capture the current port's operands this cycle
    logic select;   // SRAM chip selected
    logic readEn;   // output enable for a read access
    logic writeEn;  // write strobe for a write access
    logic done;     // final cycle of an access
  } arbStrobe_t;

endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic [NUM_PORTS-1:0] weIn,
  output logic [PORT_W-1:0]    curPort,
  output arbStrobe_t           strobe,
  output logic                 busy
);

  localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);
  localparam logic [PORT_W:0]   MAX_OTHERS = (PORT_W + 1)'(NUM_PORTS - 1);

  arbState_e         state;
  logic              isWrite;
  logic [PORT_W-1:0] nextPort;
  logic              curReq;

  assign nextPort = (curPort == LAST_PORT) ? '0 : curPort + 1'b1;
  assign curReq   = reqIn[curPort];

  // Rotation pointer advances after an idle check or after a finished access.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CHECK;
      curPort <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_CHECK: begin
          if (curReq) begin
            state   <= ST_SETUP;
            isWrite <= weIn[curPort];
          end else begin
            curPort <= nextPort;
          end
        end
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE: begin
          state   <= ST_CHECK;
          curPort <= nextPort;
        end
        default: state <= ST_CHECK;
      endcase
    end
  end

  always_comb begin
    strobe.latch   = (state == ST_CHECK) && curReq;
    strobe.select  = (state == ST_SETUP) || (state == ST_STROBE);
    strobe.readEn  = strobe.select && !isWrite;
    strobe.writeEn = (state == ST_STROBE) && isWrite;
    strobe.done    = (state == ST_STROBE);
  end

  assign busy = strobe.select;

  // Busy covers exactly one setup and one strobe cycle.
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 !busy); // R8

  // Count accesses granted to other ports while a request waits.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gWait
    logic [PORT_W:0] otherSlots;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        otherSlots <= '0;
      end else if (!reqIn[g] || (strobe.done && curPort == PORT_W'(g))) begin
        otherSlots <= '0;
      end else if (strobe.done) begin
        otherSlots <= otherSlots + 1'b1;
      end
    end

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      otherSlots <= MAX_OTHERS); // R9
  end

endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PORT_W-1:0]           curPort,
  input  arbStrobe_t                  strobe,
  input  logic [NUM_PORTS*ADDR_W-1:0] addrIn,
  input  logic [NUM_PORTS*DATA_W-1:0] wdataIn,
  input  logic [DATA_W-1:0]           sramRdata,
  output logic [ADDR_W-1:0]           sramAddr,
  output logic [DATA_W-1:0]           sramWdata,
  output logic                        sramCeN,
  output logic                        sramOeN,
  output logic                        sramWeN,
  output logic [NUM_PORTS*DATA_W-1:0] rdataOut,
  output logic [NUM_PORTS-1:0]        ackOut
);

  logic [ADDR_W-1:0] portAddr  [NUM_PORTS];
  logic [DATA_W-1:0] portWdata [NUM_PORTS];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gUnpack
    assign portAddr[g]  = addrIn[g*ADDR_W +: ADDR_W];
    assign portWdata[g] = wdataIn[g*DATA_W +: DATA_W];
  end

  // Operand registers hold still from setup through the cycle after the strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.latch) begin
      addrQ  <= portAddr[curPort];
      wdataQ <= portWdata[curPort];
    end
  end

  assign sramAddr  = addrQ;
  assign sramWdata = wdataQ;
  assign sramCeN   = !strobe.select;
  assign sramOeN   = !strobe.readEn;
  assign sramWeN   = !strobe.writeEn;

  // Per-port read capture and acknowledge.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    logic [DATA_W-1:0] rdQ;
    logic              ackQ;
    logic              mine;

    assign mine = strobe.done && (curPort == PORT_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdQ  <= '0;
        ackQ <= 1'b0;
      end else begin
        ackQ <= mine;
        if (mine && strobe.readEn) rdQ <= sramRdata;
      end
    end

    assign rdataOut[g*DATA_W +: DATA_W] = rdQ;
    assign ackOut[g] = ackQ;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      ackOut[g] |=> !ackOut[g]); // R5
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut)); // R5

  AST_ACK_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |-> $past(!sramCeN)); // R8

  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> ($stable(sramAddr) && $stable(sramWdata) && $past(!sramCeN))); // R6

  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> ($stable(sramAddr) && $stable(sramWdata))); // R6

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |=> sramWeN); // R6

  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN || !sramOeN) |-> !sramCeN); // R7

  AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN)); // R7

endmodule

// File: rtl/memArbiter.sv
module memArbiter
  import arbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqIn,
  input  logic [NUM_PORTS-1:0]        weIn,
  input  logic [NUM_PORTS*ADDR_W-1:0] addrIn,
  input  logic [NUM_PORTS*DATA_W-1:0] wdataIn,
  output logic [NUM_PORTS*DATA_W-1:0] rdataOut,
  output logic [NUM_PORTS-1:0]        ackOut,
  output logic                        busyOut,
  output logic [ADDR_W-1:0]           sramAddr,
  output logic [DATA_W-1:0]           sramWdata,
  input  logic [DATA_W-1:0]           sramRdata,
  output logic                        sramCeN,
  output logic                        sramOeN,
  output logic                        sramWeN
);

  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [PORT_W-1:0] curPort;
  arbStrobe_t        strobe;

  arbCtrl #(
    .NUM_PORTS (NUM_PORTS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (reqIn),
    .weIn    (weIn),
    .curPort (curPort),
    .strobe  (strobe),
    .busy    (busyOut)
  );

  arbDatapath #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .curPort   (curPort),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .wdataIn   (wdataIn),
    .sramRdata (sramRdata),
    .sramAddr  (sramAddr),
    .sramWdata (sramWdata),
    .sramCeN   (sramCeN),
    .sramOeN   (sramOeN),
    .sramWeN   (sramWeN),
    .rdataOut  (rdataOut),
    .ackOut    (ackOut)
  );

endmodule

// File: tb/sim_memArbiter.sv
`timescale 1ns/1ps
module sim_memArbiter;

  localparam int NP = 4;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NV = 13;

  // Vector: {port[1:0], write, addr[5:0], wdata[7:0], expected read[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 1'b1, 6'h05, 8'h3C, 8'h00},
    {2'd1, 1'b1, 6'h2A, 8'hA5, 8'h00},
    {2'd2, 1'b1, 6'h3F, 8'h81, 8'h00},
    {2'd3, 1'b1, 6'h00, 8'h7E, 8'h00},
    {2'd3, 1'b0, 6'h05, 8'h00, 8'h3C},
    {2'd2, 1'b0, 6'h2A, 8'h00, 8'hA5},
    {2'd1, 1'b0, 6'h3F, 8'h00, 8'h81},
    {2'd0, 1'b0, 6'h00, 8'h00, 8'h7E},
    {2'd1, 1'b1, 6'h05, 8'h11, 8'h00},
    {2'd2, 1'b0, 6'h05, 8'h00, 8'h11},
    {2'd0, 1'b0, 6'h3F, 8'h00, 8'h81},
    {2'd3, 1'b1, 6'h3F, 8'h00, 8'h00},
    {2'd3, 1'b0, 6'h3F, 8'h00, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [NP-1:0]     req, weV, ack;
  logic [NP*AW-1:0]  addrV;
  logic [NP*DW-1:0]  wdV, rdV;
  logic              busy, ceN, oeN, weN;
  logic [AW-1:0]     sAddr;
  logic [DW-1:0]     sWdata, sRdata;
  logic [DW-1:0]     mem [1<<AW];

  int nChecks = 0;
  int nFails  = 0;
  int ackAt [NP];
  int lastAck [NP];

  always #10 clk = ~clk;

  memArbiter #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(req), .weIn(weV), .addrIn(addrV),
    .wdataIn(wdV), .rdataOut(rdV), .ackOut(ack), .busyOut(busy),
    .sramAddr(sAddr), .sramWdata(sWdata), .sramRdata(sRdata),
    .sramCeN(ceN), .sramOeN(oeN), .sramWeN(weN)
  );

  // SRAM model: asynchronous read, write on the clock while strobed.
  assign sRdata = (!ceN && !oeN) ? mem[sAddr] : 8'h00;
  always @(posedge clk) if (!ceN && !weN) mem[sAddr] <= sWdata;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Bus monitor for strobe timing, busy and acknowledge shape.
  logic [AW-1:0] pAddr;
  logic [DW-1:0] pWdata;
  logic          pWeN, pCeN;
  logic [NP-1:0] pAck;
  always @(negedge clk) begin
    if (rstN) begin
      if (!weN) begin
        check(sAddr == pAddr && sWdata == pWdata, "R6", "setup stability",
              {sAddr, sWdata}, {pAddr, pWdata});
        check(!pCeN && pWeN, "R6", "strobe preceded by selected setup",
              {pCeN, pWeN}, 2'b01);
      end
      if (weN && !pWeN)
        check(sAddr == pAddr && sWdata == pWdata, "R6", "hold stability",
              {sAddr, sWdata}, {pAddr, pWdata});
      if (!oeN || !weN)
        check(!ceN && !(!oeN && !weN), "R7", "enable exclusivity",
              {ceN, oeN, weN}, 0);
      check(busy == !ceN, "R8", "busy vs select", busy, !ceN);
      check($onehot0(ack) && ((ack & pAck) == '0), "R5", "ack pulse shape", ack, 0);
    end
    pAddr = sAddr; pWdata = sWdata; pWeN = weN; pCeN = ceN; pAck = ack;
  end

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(ceN && oeN && weN, "R1", "SRAM controls in reset", {ceN, oeN, weN}, 3'b111);
    check(ack == '0 && !busy, "R1", "ack and busy in reset", {ack, busy}, 0);
    rstN = 1'b1;
  endtask

  task automatic doAccess(input int port, input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] exp);
    int waited = 0;
    @(negedge clk);
    req[port] = 1'b1;
    weV[port] = we;
    addrV[port*AW +: AW] = a;
    wdV[port*DW +: DW] = d;
    do begin
      @(negedge clk);
      waited++;
    end while (!ack[port] && waited < 100);
    check(ack[port], "R4", "access acknowledged", ack[port], 1);
    check(waited <= 3*NP, "R9", "single access wait", waited, 3*NP);
    if (!we)
      check(rdV[port*DW +: DW] == exp, "R4", "read data", rdV[port*DW +: DW], exp);
    req[port] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    req = '0; weV = '0; addrV = '0; wdV = '0; rstN = 1'b0;
    pAddr = '0; pWdata = '0; pWeN = 1'b1; pCeN = 1'b1; pAck = '0;
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
    applyReset();

    // R4: table of writes and cross-port reads.
    for (int i = 0; i < NV; i++)
      doAccess(int'(VEC[i][24:23]), VEC[i][22], VEC[i][21:16], VEC[i][15:8], VEC[i][7:0]);

    // R2: all ports request from reset release.
    @(negedge clk);
    rstN = 1'b0;
    req = '1; weV = '0;
    addrV = {6'h05, 6'h2A, 6'h3F, 6'h00};
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int p = 0; p < NP; p++) ackAt[p] = 0;
    for (int n = 1; n <= 3*NP + 2; n++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++)
        if (ack[p] && req[p]) begin
          ackAt[p] = n;
          req[p] = 1'b0;
        end
    end
    for (int p = 0; p < NP; p++)
      check(ackAt[p] == 3*(p+1), "R2", "rotation ack cycle", ackAt[p], 3*(p+1));
    check(rdV == {8'h11, 8'hA5, 8'h00, 8'h7E}, "R4", "parallel reads", rdV,
          {8'h11, 8'hA5, 8'h00, 8'h7E});

    // R3: lone request held across acknowledges.
    @(negedge clk);
    req[2] = 1'b1; weV[2] = 1'b0; addrV[2*AW +: AW] = 6'h2A;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!ack[2] && n < 40);
      for (int k = 0; k < 2; k++) begin
        n = 0;
        do begin @(negedge clk); n++; end while (!ack[2] && n < 40);
        check(n == NP + 2, "R3", "held request ack spacing", n, NP + 2);
        check(rdV[2*DW +: DW] == 8'hA5, "R4", "repeated read", rdV[2*DW +: DW], 8'hA5);
      end
    end
    req[2] = 1'b0;

    // R9 and R2: all ports saturated.
    @(negedge clk);
    req = '1; weV = '0;
    begin
      int lastPort = -1;
      for (int p = 0; p < NP; p++) lastAck[p] = -1;
      for (int c = 1; c <= 60; c++) begin
        @(negedge clk);
        for (int p = 0; p < NP; p++)
          if (ack[p]) begin
            if (lastAck[p] >= 0)
              check(c - lastAck[p] <= 3*NP, "R9", "saturated wait", c - lastAck[p], 3*NP);
            if (lastPort >= 0)
              check(p == (lastPort + 1) % NP, "R2", "saturated order", p, (lastPort + 1) % NP);
            lastAck[p] = c;
            lastPort = p;
          end
      end
    end
    req = '0;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule